// File: doc/BRIEF.md
# Split Completion Error Message Handler

This block sits beside the outstanding-request tracker of a PCI-X style bridge. It looks at each decoded split completion message and picks out those that report an uncorrectable data error against one of the bridge's own outstanding configuration or I/O write requests. On such a message it does four things. It updates sticky status bits and interrupt status bits, as enables and mask bits allow. It can pulse a system-error output. It tells the tracker to drop the request named by the message's tag.

Upstream logic presents one message per cycle. Each message is a class, an index, a completer attribute word, a tag, and a flag that says whether the tag matches an outstanding configuration or I/O write. Software reads the status and interrupt status vectors and clears bits by writing ones. Every effect of a message appears on the ports one clock after the message is presented.

Top module: `split_err_msg_handler`

## Requirements
- R1: A message is claimed only when `msgValid` and `tagHit` are both high and (class, index) is (2h, 01h) or (1h, 02h). Any other message changes no status bit, no interrupt bit, and pulses neither `serrOut` nor `discardValid`.
- R2: One clock after a claimed message, `discardValid` is high for one cycle and `discardTag` equals that message's `msgTag`.
- R3: A claimed message with `cfgParErrResp` set sets `statusBits[0]` (master parity error). With `cfgParErrResp` clear it leaves bits 0 and 1 alone and does not pulse `serrOut`.
- R4: A claimed message with `cfgParErrResp` set sets `irqStatus[0]` only when `maskMstPar` is clear.
- R5: One clock after a claimed message, `serrOut` is high for exactly one cycle if `cfgParErrResp` and `cfgSerrEn` are set and `cfgRecoverEn` is clear. Otherwise it stays low. Back-to-back qualifying messages give back-to-back pulses.
- R6: Each `serrOut` pulse sets `statusBits[1]` (system error asserted). It also sets `irqStatus[1]` when `maskSerrAsserted` is clear, and `irqStatus[2]` when `enSerrDetectIrq` is set.
- R7: A claimed message with bit 30 of `msgAttr` set sets `statusBits[2]` (received split error message), whatever `cfgParErrResp` is. It also sets `irqStatus[3]` when `maskRcvMsg` is clear.
- R8: Status and interrupt status bits are sticky. A one in `stsClr`/`irqClr` clears only that bit position. A set in the same cycle wins over the clear.
- R9: `irqOut` is the OR of all `irqStatus` bits.
- R10: After reset every status bit, interrupt status bit, `serrOut`, `discardValid` and `discardTag` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Decoded message present this cycle |
| msgClass | input | 4 | Message class |
| msgIndex | input | 8 | Message index |
| msgAttr | input | 32 | Completer attribute word |
| msgTag | input | 5 | Tag of the request the message refers to |
| tagHit | input | 1 | Tag matches an outstanding configuration or I/O write |
| cfgParErrResp | input | 1 | Parity error response enable |
| cfgSerrEn | input | 1 | System error enable |
| cfgRecoverEn | input | 1 | Uncorrectable data error recovery enable |
| maskMstPar | input | 1 | Mask for master parity interrupt |
| maskSerrAsserted | input | 1 | Mask for system-error-asserted interrupt |
| enSerrDetectIrq | input | 1 | Enable for system-error-detected interrupt |
| maskRcvMsg | input | 1 | Mask for received-message interrupt |
| stsClr | input | 3 | Write-one-to-clear strobes for status bits |
| irqClr | input | 4 | Write-one-to-clear strobes for interrupt bits |
| statusBits | output | 3 | Sticky status: 0 master parity, 1 system error asserted, 2 received split error message |
| irqStatus | output | 4 | Sticky interrupt status: 0 master parity, 1 system error asserted, 2 system error detected, 3 received message |
| irqOut | output | 1 | OR of interrupt status bits |
| serrOut | output | 1 | One-cycle system error pulse |
| discardValid | output | 1 | One-cycle discard request |
| discardTag | output | 5 | Tag to discard |

## Verification
Every effect of a message lands one clock later. So a wrong decode, a wrong enable term or a wrong mask term shows up as a wrong bit on `statusBits`, `irqStatus`, `serrOut` or `discardValid` on the very next edge. A sticky bit that leaks or clears the wrong position shows on the next cycle after the stray clear or idle cycle. The bench keeps a running model of every sticky bit and checks all outputs every cycle. Any such error therefore appears within one clock of its cause.

// File: rtl/split_err_pkg.sv
package split_err_pkg;

  localparam int STS_W = 3;
  localparam int IRQ_W = 4;

  // status bit positions (software decodes these)
  localparam int STS_MST_PAR = 0;
  localparam int STS_SERR    = 1;
  localparam int STS_RCV_MSG = 2;

  // interrupt status bit positions
  localparam int IRQ_MST_PAR     = 0;
  localparam int IRQ_SERR_ASSERT = 1;
  localparam int IRQ_SERR_DETECT = 2;
  localparam int IRQ_RCV_MSG     = 3;

  // strobes from control to datapath for one message cycle
  typedef struct packed {
    logic             discard;
    logic             serr;
    logic [STS_W-1:0] stsSet;
    logic [IRQ_W-1:0] irqSet;
  } errStrobes_t;

endpackage

// File: rtl/split_err_ctrl.sv
module split_err_ctrl
  import split_err_pkg::*;
#(
  parameter int CLASS_W      = 4,
  parameter int INDEX_W      = 8,
  parameter int ATTR_W       = 32,
  parameter int ERR_ATTR_BIT = 30
) (
  input  logic               msgValid,
  input  logic [CLASS_W-1:0] msgClass,
  input  logic [INDEX_W-1:0] msgIndex,
  input  logic [ATTR_W-1:0]  msgAttr,
  input  logic               tagHit,
  input  logic               cfgParErrResp,
  input  logic               cfgSerrEn,
  input  logic               cfgRecoverEn,
  input  logic               maskMstPar,
  input  logic               maskSerrAsserted,
  input  logic               enSerrDetectIrq,
  input  logic               maskRcvMsg,
  output errStrobes_t        strobes
);

  // claimed (class, index) encodings, entry 0 = split write, entry 1 = write
  localparam int NUM_CODES = 2;
  localparam logic [NUM_CODES*CLASS_W-1:0] CODE_CLASS = {CLASS_W'(1), CLASS_W'(2)};
  localparam logic [NUM_CODES*INDEX_W-1:0] CODE_INDEX = {INDEX_W'(2), INDEX_W'(1)};

  logic [NUM_CODES-1:0] codeHit;
  logic                 claimed;
  logic                 mstParSet;
  logic                 serrFire;
  logic                 rcvMsgSet;
  logic                 unusedAttr;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    assign codeHit[g] = (msgClass == CODE_CLASS[g*CLASS_W +: CLASS_W]) &&
                        (msgIndex == CODE_INDEX[g*INDEX_W +: INDEX_W]);
  end

  assign unusedAttr = ^msgAttr;

  // R1: claim only on a matching code for an own outstanding write
  assign claimed   = msgValid && tagHit && (|codeHit);
  assign mstParSet = claimed && cfgParErrResp;
  assign serrFire  = mstParSet && cfgSerrEn && !cfgRecoverEn;
  assign rcvMsgSet = claimed && msgAttr[ERR_ATTR_BIT];

  always_comb begin
    strobes = '0;
    strobes.discard                 = claimed;
    strobes.serr                    = serrFire;
    strobes.stsSet[STS_MST_PAR]     = mstParSet;
    strobes.stsSet[STS_SERR]        = serrFire;
    strobes.stsSet[STS_RCV_MSG]     = rcvMsgSet;
    strobes.irqSet[IRQ_MST_PAR]     = mstParSet && !maskMstPar;
    strobes.irqSet[IRQ_SERR_ASSERT] = serrFire && !maskSerrAsserted;
    strobes.irqSet[IRQ_SERR_DETECT] = serrFire && enSerrDetectIrq;
    strobes.irqSet[IRQ_RCV_MSG]     = rcvMsgSet && !maskRcvMsg;
  end

endmodule

// File: rtl/split_err_datapath.sv
module split_err_datapath
  import split_err_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  errStrobes_t      strobes,
  input  logic [TAG_W-1:0] msgTag,
  input  logic [STS_W-1:0] stsClr,
  input  logic [IRQ_W-1:0] irqClr,
  output logic [STS_W-1:0] statusBits,
  output logic [IRQ_W-1:0] irqStatus,
  output logic             irqOut,
  output logic             serrOut,
  output logic             discardValid,
  output logic [TAG_W-1:0] discardTag
);

  logic [STS_W-1:0] statusQ;
  logic [IRQ_W-1:0] irqQ;

  // sticky status bits: set wins over write-one-to-clear
  for (genvar i = 0; i < STS_W; i++) begin : g_sts
    always_ff @(posedge clk) begin
      if (!rstN)                  statusQ[i] <= 1'b0;
      else if (strobes.stsSet[i]) statusQ[i] <= 1'b1;
      else if (stsClr[i])         statusQ[i] <= 1'b0;
    end

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !stsClr[i]) |=> statusQ[i]); // R8
    AST_STS_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobes.stsSet[i] |=> statusQ[i]); // R8
  end

  for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (!rstN)                  irqQ[i] <= 1'b0;
      else if (strobes.irqSet[i]) irqQ[i] <= 1'b1;
      else if (irqClr[i])         irqQ[i] <= 1'b0;
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (irqQ[i] && !irqClr[i]) |=> irqQ[i]); // R8
  end

  // one-cycle pulses for system error and discard
  always_ff @(posedge clk) begin
    if (!rstN) begin
      serrOut      <= 1'b0;
      discardValid <= 1'b0;
      discardTag   <= '0;
    end else begin
      serrOut      <= strobes.serr;
      discardValid <= strobes.discard;
      if (strobes.discard) discardTag <= msgTag;
    end
  end

  assign statusBits = statusQ;
  assign irqStatus  = irqQ;
  assign irqOut     = |irqQ;

  AST_SERR_MARKS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> statusQ[STS_SERR]); // R6

endmodule

// File: rtl/split_err_msg_handler.sv
module split_err_msg_handler
  import split_err_pkg::*;
#(
  parameter int CLASS_W      = 4,
  parameter int INDEX_W      = 8,
  parameter int ATTR_W       = 32,
  parameter int ERR_ATTR_BIT = 30,
  parameter int TAG_W        = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               msgValid,
  input  logic [CLASS_W-1:0] msgClass,
  input  logic [INDEX_W-1:0] msgIndex,
  input  logic [ATTR_W-1:0]  msgAttr,
  input  logic [TAG_W-1:0]   msgTag,
  input  logic               tagHit,
  input  logic               cfgParErrResp,
  input  logic               cfgSerrEn,
  input  logic               cfgRecoverEn,
  input  logic               maskMstPar,
  input  logic               maskSerrAsserted,
  input  logic               enSerrDetectIrq,
  input  logic               maskRcvMsg,
  input  logic [2:0]         stsClr,
  input  logic [3:0]         irqClr,
  output logic [2:0]         statusBits,
  output logic [3:0]         irqStatus,
  output logic               irqOut,
  output logic               serrOut,
  output logic               discardValid,
  output logic [TAG_W-1:0]   discardTag
);

  errStrobes_t strobes;

  split_err_ctrl #(
    .CLASS_W      (CLASS_W),
    .INDEX_W      (INDEX_W),
    .ATTR_W       (ATTR_W),
    .ERR_ATTR_BIT (ERR_ATTR_BIT)
  ) i_ctrl (
    .msgValid         (msgValid),
    .msgClass         (msgClass),
    .msgIndex         (msgIndex),
    .msgAttr          (msgAttr),
    .tagHit           (tagHit),
    .cfgParErrResp    (cfgParErrResp),
    .cfgSerrEn        (cfgSerrEn),
    .cfgRecoverEn     (cfgRecoverEn),
    .maskMstPar       (maskMstPar),
    .maskSerrAsserted (maskSerrAsserted),
    .enSerrDetectIrq  (enSerrDetectIrq),
    .maskRcvMsg       (maskRcvMsg),
    .strobes          (strobes)
  );

  split_err_datapath #(
    .TAG_W (TAG_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .msgTag       (msgTag),
    .stsClr       (stsClr),
    .irqClr       (irqClr),
    .statusBits   (statusBits),
    .irqStatus    (irqStatus),
    .irqOut       (irqOut),
    .serrOut      (serrOut),
    .discardValid (discardValid),
    .discardTag   (discardTag)
  );

  AST_DISCARD_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rstN)
    discardValid |-> $past(msgValid && tagHit)); // R1
  AST_SERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> $past(cfgParErrResp && cfgSerrEn && !cfgRecoverEn && msgValid)); // R5
  AST_SERR_NEEDS_PARRESP: assert property (@(posedge clk) disable iff (!rstN)
    serrOut |-> statusBits[0]); // R3
  AST_MSTPAR_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[0]) |-> ($past(!maskMstPar) && statusBits[0])); // R4
  AST_RCV_IRQ_MASK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus[3]) |-> ($past(!maskRcvMsg) && statusBits[2])); // R7

endmodule

// File: tb/test_split_err_msg_handler.sv
module test_split_err_msg_handler;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [3:0]  msgClass = '0;
  logic [7:0]  msgIndex = '0;
  logic [31:0] msgAttr = '0;
  logic [4:0]  msgTag = '0;
  logic        tagHit = 1'b0;
  logic        cfgParErrResp = 1'b0, cfgSerrEn = 1'b0, cfgRecoverEn = 1'b0;
  logic        maskMstPar = 1'b0, maskSerrAsserted = 1'b0, enSerrDetectIrq = 1'b0, maskRcvMsg = 1'b0;
  logic [2:0]  stsClr = '0;
  logic [3:0]  irqClr = '0;
  logic [2:0]  statusBits;
  logic [3:0]  irqStatus;
  logic        irqOut, serrOut, discardValid;
  logic [4:0]  discardTag;

  // configuration to apply with the next step
  logic nPer = 0, nSerr = 0, nRec = 0, nMmp = 0, nMsa = 0, nDet = 0, nMrm = 0;

  typedef struct {
    string      req;
    logic       serr;
    logic       disc;
    logic [4:0] tag;
    logic [2:0] sts;
    logic [3:0] irq;
  } exp_t;

  exp_t       expQ[$];
  logic [2:0] expSts = '0;
  logic [3:0] expIrq = '0;
  int         nChecks = 0;
  int         nFails = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  split_err_msg_handler i_split_err_msg_handler (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgClass(msgClass),
    .msgIndex(msgIndex), .msgAttr(msgAttr), .msgTag(msgTag), .tagHit(tagHit),
    .cfgParErrResp(cfgParErrResp), .cfgSerrEn(cfgSerrEn), .cfgRecoverEn(cfgRecoverEn),
    .maskMstPar(maskMstPar), .maskSerrAsserted(maskSerrAsserted),
    .enSerrDetectIrq(enSerrDetectIrq), .maskRcvMsg(maskRcvMsg),
    .stsClr(stsClr), .irqClr(irqClr), .statusBits(statusBits), .irqStatus(irqStatus),
    .irqOut(irqOut), .serrOut(serrOut), .discardValid(discardValid), .discardTag(discardTag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and push the expected result
  task automatic step(input logic v, input logic [3:0] c, input logic [7:0] ix,
                      input logic a30, input logic [4:0] t, input logic h,
                      input logic [2:0] sc, input logic [3:0] ic, input string req);
    exp_t e;
    logic claim, mp, se, rm;
    @(negedge clk);
    msgValid = v; msgClass = c; msgIndex = ix; msgTag = t; tagHit = h;
    msgAttr = 32'h1234_5678 & ~32'h4000_0000;
    msgAttr[30] = a30;
    stsClr = sc; irqClr = ic;
    cfgParErrResp = nPer; cfgSerrEn = nSerr; cfgRecoverEn = nRec;
    maskMstPar = nMmp; maskSerrAsserted = nMsa; enSerrDetectIrq = nDet; maskRcvMsg = nMrm;
    claim = v && h && ((c == 4'h2 && ix == 8'h01) || (c == 4'h1 && ix == 8'h02));
    mp = claim && nPer;
    se = mp && nSerr && !nRec;
    rm = claim && a30;
    expSts = (expSts & ~sc) | {rm, se, mp};
    expIrq = (expIrq & ~ic) | {rm && !nMrm, se && nDet, se && !nMsa, mp && !nMmp};
    e.req = req; e.serr = se; e.disc = claim; e.tag = t; e.sts = expSts; e.irq = expIrq;
    expQ.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b000, 4'b0000, req);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(e.req, "R5 serrOut", serrOut, e.serr);
      check(e.req, "R2 discardValid", discardValid, e.disc);
      if (e.disc) check(e.req, "R2 discardTag", discardTag, e.tag);
      check(e.req, "statusBits", statusBits, e.sts);
      check(e.req, "irqStatus", irqStatus, e.irq);
      check(e.req, "R9 irqOut", irqOut, |e.irq);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check("R10", "reset status", statusBits, 0);
    check("R10", "reset irq", irqStatus, 0);
    check("R10", "reset serr/discard", {serrOut, discardValid, irqOut}, 0);
    check("R10", "reset tag", discardTag, 0);

    // R3 R4 R5 R6 R7: everything enabled, split write code
    nPer = 1; nSerr = 1; nRec = 0; nMmp = 0; nMsa = 0; nDet = 1; nMrm = 0;
    step(1, 4'h2, 8'h01, 1, 5'h05, 1, 3'b000, 4'b0000, "R3_R4_R5_R6_R7 full");
    idle("R5 pulse ends, R8 hold");
    idle("R8 hold");

    // R8: clear per bit position
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b010, 4'b0001, "R8 partial clear");
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b111, 4'b1111, "R8 clear all");

    // R7 R3: parity response off, write code, attr bit 30 set
    nPer = 0;
    step(1, 4'h1, 8'h02, 1, 5'h1A, 1, 3'b000, 4'b0000, "R7_R3 no parresp");
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b111, 4'b1111, "R8 clear");

    // R5: recovery enabled suppresses system error
    nPer = 1; nRec = 1;
    step(1, 4'h2, 8'h01, 0, 5'h03, 1, 3'b000, 4'b0000, "R5 recover suppresses");
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b111, 4'b1111, "R8 clear");

    // R4 R6 R9: masks set, detect irq disabled
    nRec = 0; nMmp = 1; nMsa = 1; nDet = 0; nMrm = 1;
    step(1, 4'h1, 8'h02, 1, 5'h11, 1, 3'b000, 4'b0000, "R4_R6_R9 masked");
    idle("R9 irqOut low with status set");
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b111, 4'b1111, "R8 clear");

    // R1: ignored messages
    nMmp = 0; nMsa = 0; nDet = 1; nMrm = 0;
    step(1, 4'h2, 8'h02, 1, 5'h07, 1, 3'b000, 4'b0000, "R1 wrong index");
    step(1, 4'h1, 8'h01, 1, 5'h07, 1, 3'b000, 4'b0000, "R1 wrong pair");
    step(1, 4'h2, 8'h01, 1, 5'h07, 0, 3'b000, 4'b0000, "R1 no tag hit");
    step(0, 4'h2, 8'h01, 1, 5'h07, 1, 3'b000, 4'b0000, "R1 not valid");
    step(1, 4'h3, 8'h01, 1, 5'h07, 1, 3'b000, 4'b0000, "R1 wrong class");

    // R5 R2: back-to-back qualifying messages
    step(1, 4'h2, 8'h01, 0, 5'h08, 1, 3'b000, 4'b0000, "R5_R2 first");
    step(1, 4'h1, 8'h02, 1, 5'h1F, 1, 3'b000, 4'b0000, "R5_R2 second");

    // R8: set wins over clear in the same cycle
    step(1, 4'h2, 8'h01, 1, 5'h02, 1, 3'b111, 4'b1111, "R8 set beats clear");
    step(0, 4'h0, 8'h00, 0, 5'h0, 0, 3'b100, 4'b0100, "R8 single-bit clear");
    idle("R8 hold after clear");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule